// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This block turns a logical address, a 16-bit selector plus a 32-bit offset, into a 32-bit linear address. It keeps a base and a 16-bit limit for a global and a local descriptor table. It also keeps a small set of segment slots, each caching one decoded descriptor. Software-side logic first programs the two tables. It then loads a selector into a slot. The block checks the selector against the table bounds, reads the 8-byte descriptor in two 32-bit reads, checks it, and caches it. If the accessed bit in memory was clear, it writes that word back with the bit set.

Once a slot is loaded, each translation request names a slot, an offset and a read or write direction. One cycle later the block returns either the linear address or a fault cause. The checks cover the null selector, the access rights and the segment limit. The segment limit may be byte or 4 KB granular, and the segment may expand up or expand down. While a descriptor load is in flight, the block raises busy. New loads and translations are ignored until the load is done.

Top module: `seg_xlate`

## Requirements
- R1: After reset, busy, loadDone and xlValid are low. Every slot is null, so a translation through any slot returns fault code 1.
- R2: A selector holds the descriptor index in bits 15:3, the table choice in bit 2 (0 global, 1 local) and the requested level (RPL) in bits 1:0. The descriptor's low word is read from table base + index*8, then its high word from that address + 4.
- R3: If index*8+7 is greater than the chosen table's limit, the load ends with loadFault = 2, with loadDone two cycles after the request edge and no memory read issued.
- R4: Loading a global selector with index 0 (the null selector) ends with loadFault = 0 two cycles after the request, with no memory read. The slot becomes null, and later translations through it return fault 1. A local selector with index 0 is an ordinary entry.
- R5: The low word carries limit[15:0] in bits 15:0 and base[15:0] in bits 31:16. The high word carries base[23:16] in bits 7:0, the access byte in bits 15:8, limit[19:16] in bits 19:16, G in bit 23 and base[31:24] in bits 31:24. The access byte carries P in bit 15, DPL in bits 14:13, S in bit 12, E in bit 11, ED/C in bit 10, W/R in bit 9 and A in bit 8. Load faults are checked in this order: P=0 gives 3, S=0 gives 5, and the larger of CPL and RPL being above DPL gives 6. A failed load leaves the target slot unchanged.
- R6: After a successful load whose A bit was 0, exactly one write stores the high word with bit 8 set at the descriptor address + 4. If A was already 1, no write is made.
- R7: With G=0 the effective limit is the 20-bit limit. With G=1 it is the limit shifted left by 12 with bits 11:0 set to ones.
- R8: For code segments and data segments with ED=0, an offset above the effective limit gives fault 4. For data segments with ED=1, an offset at or below the limit gives fault 4.
- R9: A write to a code segment (E=1), a write to a data segment with W=0, or a read of a code segment with R=0 gives fault 5. A rights fault takes precedence over a limit fault.
- R10: xlValid is high for one cycle, on the cycle after an accepted request. The linear address is base + offset modulo 2^32 when xlFault = 0, and 0 when a fault is reported.
- R11: busy is high from the cycle after an accepted load until loadDone. loadDone is a single-cycle pulse. Translation and load requests made while busy are ignored, so no xlValid follows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tableWe | input | 1 | Write strobe for a table base/limit pair |
| tableSel | input | 1 | Table chosen by tableWe: 0 global, 1 local |
| tableBase | input | 32 | Table base linear address |
| tableLimit | input | 16 | Table limit in bytes |
| loadReq | input | 1 | Start a selector load |
| loadSlot | input | SLOT_W | Slot to load |
| loadSel | input | 16 | Selector to load |
| cpl | input | 2 | Current privilege level used by the load check |
| busy | output | 1 | A descriptor load is in progress |
| loadDone | output | 1 | One-cycle pulse at load completion |
| loadFault | output | 3 | Load result code |
| memRdReq | output | 1 | Descriptor read request, held until memRdValid |
| memRdAddr | output | 32 | Descriptor read address |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Read data |
| memWrReq | output | 1 | One-cycle write of the accessed bit |
| memWrAddr | output | 32 | Write address |
| memWrData | output | 32 | Write data |
| xlReq | input | 1 | Translation request |
| xlSlot | input | SLOT_W | Slot used for the translation |
| xlOffset | input | 32 | Offset within the segment |
| xlWrite | input | 1 | 1 write, 0 read |
| xlValid | output | 1 | Translation result valid |
| xlLinear | output | 32 | Linear address |
| xlFault | output | 3 | Translation fault code |

## Verification
A translation result is due on the cycle after the edge that accepts xlReq. The bench drives each request on a falling edge and samples xlValid, xlFault and xlLinear on the next falling edge. Loads that stop at the null or table-limit check must pulse loadDone exactly two cycles after the request edge. The bench counts falling edges to that pulse and compares the memory read count before and after. Loads that read memory depend on the responder's latency, so for those the bench waits for loadDone. It then checks the result code, the write-back word held in its memory model, and later translations through the loaded slot.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_NULL   = 3'd1,
    FLT_TBL    = 3'd2,
    FLT_ABSENT = 3'd3,
    FLT_SEGLIM = 3'd4,
    FLT_RIGHTS = 3'd5,
    FLT_PRIV   = 3'd6
  } fault_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capLoad;
    logic capLo;
    logic commit;
    logic setNull;
    logic rdHi;
  } ctrlStrobe_t;

  // decoded conditions from datapath to control
  typedef struct packed {
    logic selNull;
    logic tblOver;
    logic absent;
    logic sysSeg;
    logic privBad;
    logic accSet;
  } dpStatus_t;

  typedef struct packed {
    logic        live;
    logic [31:0] base;
    logic [19:0] limit;
    logic        gran;
    logic        code;
    logic        dirBit;
    logic        rwBit;
  } segCache_t;

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadReq,
  input  logic        memRdValid,
  input  dpStatus_t   status,
  output ctrlStrobe_t stb,
  output logic        memRdReq,
  output logic        memWrReq,
  output logic        busy,
  output logic        loadDone,
  output logic [2:0]  loadFault
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_RDLO, ST_RDHI, ST_WRBK
  } state_e;

  state_e stateQ, stateD;
  logic   doneSet;
  fault_e faultSet;

  always_comb begin
    stateD   = stateQ;
    stb      = '0;
    memRdReq = 1'b0;
    memWrReq = 1'b0;
    doneSet  = 1'b0;
    faultSet = FLT_NONE;
    case (stateQ)
      ST_IDLE: begin
        if (loadReq) begin
          stb.capLoad = 1'b1;
          stateD      = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (status.selNull) begin
          stb.setNull = 1'b1;
          doneSet     = 1'b1;
          stateD      = ST_IDLE;
        end else if (status.tblOver) begin
          doneSet  = 1'b1;
          faultSet = FLT_TBL;
          stateD   = ST_IDLE;
        end else begin
          stateD = ST_RDLO;
        end
      end
      ST_RDLO: begin
        memRdReq = 1'b1;
        if (memRdValid) begin
          stb.capLo = 1'b1;
          stateD    = ST_RDHI;
        end
      end
      ST_RDHI: begin
        memRdReq = 1'b1;
        stb.rdHi = 1'b1;
        if (memRdValid) begin
          if (status.absent) begin
            faultSet = FLT_ABSENT;
            doneSet  = 1'b1;
            stateD   = ST_IDLE;
          end else if (status.sysSeg) begin
            faultSet = FLT_RIGHTS;
            doneSet  = 1'b1;
            stateD   = ST_IDLE;
          end else if (status.privBad) begin
            faultSet = FLT_PRIV;
            doneSet  = 1'b1;
            stateD   = ST_IDLE;
          end else begin
            stb.commit = 1'b1;
            if (status.accSet) begin
              doneSet = 1'b1;
              stateD  = ST_IDLE;
            end else begin
              stateD = ST_WRBK;
            end
          end
        end
      end
      ST_WRBK: begin
        memWrReq = 1'b1;
        doneSet  = 1'b1;
        stateD   = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      loadDone  <= 1'b0;
      loadFault <= 3'd0;
    end else begin
      stateQ    <= stateD;
      loadDone  <= doneSet;
      loadFault <= doneSet ? faultSet : FLT_NONE;
    end
  end

  assign busy = (stateQ != ST_IDLE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> !loadDone);                                          // R11
  AST_NO_READ_ON_TBL: assert property (@(posedge clk) disable iff (!rstN)
    (loadDone && loadFault == FLT_TBL) |-> !$past(memRdReq));         // R3
  AST_WRBK_AFTER_HI: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq |-> $past(memRdValid));                                  // R6
  AST_LOAD_CODE_SET: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> (loadFault != FLT_NULL && loadFault != FLT_SEGLIM)); // R5

endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic              busy,
  input  logic              tableWe,
  input  logic              tableSel,
  input  logic [31:0]       tableBase,
  input  logic [15:0]       tableLimit,
  input  logic [SLOT_W-1:0] loadSlot,
  input  logic [15:0]       loadSel,
  input  logic [1:0]        cpl,
  input  logic [31:0]       memRdData,
  input  logic              xlReq,
  input  logic [SLOT_W-1:0] xlSlot,
  input  logic [31:0]       xlOffset,
  input  logic              xlWrite,
  output dpStatus_t         status,
  output logic [31:0]       memRdAddr,
  output logic [31:0]       memWrAddr,
  output logic [31:0]       memWrData,
  output logic              xlValid,
  output logic [31:0]       xlLinear,
  output logic [2:0]        xlFault
);

  logic [31:0]       gdtBase, ldtBase, descAddr, loWordQ, hiWordQ;
  logic [15:0]       gdtLim, ldtLim, selQ, tblEnd;
  logic [SLOT_W-1:0] slotQ;
  logic [1:0]        cplQ, effPl;
  logic [12:0]       idx;
  logic              ti;
  segCache_t         newEntry, pick;
  segCache_t         slotView [NUM_SLOTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gdtBase <= '0; gdtLim <= '0;
      ldtBase <= '0; ldtLim <= '0;
    end else if (tableWe) begin
      if (tableSel) begin
        ldtBase <= tableBase; ldtLim <= tableLimit;
      end else begin
        gdtBase <= tableBase; gdtLim <= tableLimit;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0; slotQ <= '0; cplQ <= '0;
      loWordQ <= '0; hiWordQ <= '0;
    end else begin
      if (stb.capLoad) begin
        selQ  <= loadSel;
        slotQ <= loadSlot;
        cplQ  <= cpl;
      end
      if (stb.capLo)  loWordQ <= memRdData;
      if (stb.commit) hiWordQ <= memRdData;
    end
  end

  // selector decode and table bounds
  assign idx      = selQ[15:3];
  assign ti       = selQ[2];
  assign tblEnd   = {idx, 3'b111};
  assign descAddr = (ti ? ldtBase : gdtBase) + {16'd0, idx, 3'b000};
  assign effPl    = (cplQ > selQ[1:0]) ? cplQ : selQ[1:0];

  assign status.selNull = !ti && (idx == 13'd0);
  assign status.tblOver = tblEnd > (ti ? ldtLim : gdtLim);
  assign status.absent  = !memRdData[15];
  assign status.sysSeg  = !memRdData[12];
  assign status.privBad = effPl > memRdData[14:13];
  assign status.accSet  = memRdData[8];

  assign memRdAddr = descAddr + (stb.rdHi ? 32'd4 : 32'd0);
  assign memWrAddr = descAddr + 32'd4;
  assign memWrData = hiWordQ | 32'h0000_0100;

  always_comb begin
    newEntry.live   = 1'b1;
    newEntry.base   = {memRdData[31:24], memRdData[7:0], loWordQ[31:16]};
    newEntry.limit  = {memRdData[19:16], loWordQ[15:0]};
    newEntry.gran   = memRdData[23];
    newEntry.code   = memRdData[11];
    newEntry.dirBit = memRdData[10];
    newEntry.rwBit  = memRdData[9];
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    segCache_t slotReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotReg <= '0;
      end else if (slotQ == SLOT_W'(s)) begin
        if (stb.commit)       slotReg      <= newEntry;
        else if (stb.setNull) slotReg.live <= 1'b0;
      end
    end
    assign slotView[s] = slotReg;
  end

  // translation checks
  logic [31:0] effLim;
  logic        rightsBad, limBad, accept;
  fault_e      faultNow;

  assign pick      = slotView[xlSlot];
  assign effLim    = pick.gran ? {pick.limit, 12'hFFF} : {12'h000, pick.limit};
  assign rightsBad = xlWrite ? (pick.code || !pick.rwBit) : (pick.code && !pick.rwBit);
  assign limBad    = (!pick.code && pick.dirBit) ? (xlOffset <= effLim) : (xlOffset > effLim);
  assign accept    = xlReq && !busy;

  always_comb begin
    if (!pick.live)     faultNow = FLT_NULL;
    else if (rightsBad) faultNow = FLT_RIGHTS;
    else if (limBad)    faultNow = FLT_SEGLIM;
    else                faultNow = FLT_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xlValid  <= 1'b0;
      xlFault  <= 3'd0;
      xlLinear <= '0;
    end else begin
      xlValid  <= accept;
      xlFault  <= accept ? faultNow : FLT_NONE;
      xlLinear <= (accept && faultNow == FLT_NONE) ? pick.base + xlOffset : 32'd0;
    end
  end

  AST_XL_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    xlValid |-> !$past(busy));                                         // R11
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (xlValid && xlFault != 3'd0) |-> (xlLinear == 32'd0));             // R10
  AST_XL_CODE_SET: assert property (@(posedge clk) disable iff (!rstN)
    xlValid |-> (xlFault == 3'd0 || xlFault == 3'd1 || xlFault == 3'd4 || xlFault == 3'd5)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !xlValid |-> (xlFault == 3'd0));                                   // R10

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter  int NUM_SLOTS = 4,
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tableWe,
  input  logic              tableSel,
  input  logic [31:0]       tableBase,
  input  logic [15:0]       tableLimit,
  input  logic              loadReq,
  input  logic [SLOT_W-1:0] loadSlot,
  input  logic [15:0]       loadSel,
  input  logic [1:0]        cpl,
  output logic              busy,
  output logic              loadDone,
  output logic [2:0]        loadFault,
  output logic              memRdReq,
  output logic [31:0]       memRdAddr,
  input  logic              memRdValid,
  input  logic [31:0]       memRdData,
  output logic              memWrReq,
  output logic [31:0]       memWrAddr,
  output logic [31:0]       memWrData,
  input  logic              xlReq,
  input  logic [SLOT_W-1:0] xlSlot,
  input  logic [31:0]       xlOffset,
  input  logic              xlWrite,
  output logic              xlValid,
  output logic [31:0]       xlLinear,
  output logic [2:0]        xlFault
);

  ctrlStrobe_t stb;
  dpStatus_t   status;

  seg_xlate_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .loadReq(loadReq), .memRdValid(memRdValid),
    .status(status), .stb(stb), .memRdReq(memRdReq), .memWrReq(memWrReq),
    .busy(busy), .loadDone(loadDone), .loadFault(loadFault)
  );

  seg_xlate_dp #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy),
    .tableWe(tableWe), .tableSel(tableSel), .tableBase(tableBase),
    .tableLimit(tableLimit), .loadSlot(loadSlot), .loadSel(loadSel),
    .cpl(cpl), .memRdData(memRdData), .xlReq(xlReq), .xlSlot(xlSlot),
    .xlOffset(xlOffset), .xlWrite(xlWrite), .status(status),
    .memRdAddr(memRdAddr), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .xlValid(xlValid), .xlLinear(xlLinear), .xlFault(xlFault)
  );

endmodule

// File: tb/seg_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tableWe = 0, tableSel = 0;
  logic [31:0] tableBase = 0;
  logic [15:0] tableLimit = 0;
  logic        loadReq = 0;
  logic [1:0]  loadSlot = 0;
  logic [15:0] loadSel = 0;
  logic [1:0]  cpl = 0;
  logic        busy, loadDone;
  logic [2:0]  loadFault;
  logic        memRdReq, memWrReq;
  logic [31:0] memRdAddr, memWrAddr, memWrData;
  logic        memRdValid = 0;
  logic [31:0] memRdData = 0;
  logic        xlReq = 0, xlWrite = 0;
  logic [1:0]  xlSlot = 0;
  logic [31:0] xlOffset = 0;
  logic        xlValid;
  logic [31:0] xlLinear;
  logic [2:0]  xlFault;

  int checks = 0, fails = 0, rdCount = 0, wrCount = 0;
  bit finished = 0;
  logic [31:0] mem [0:255];

  always #4 clk = ~clk;

  seg_xlate dut_i (
    .clk(clk), .rstN(rstN), .tableWe(tableWe), .tableSel(tableSel),
    .tableBase(tableBase), .tableLimit(tableLimit), .loadReq(loadReq),
    .loadSlot(loadSlot), .loadSel(loadSel), .cpl(cpl), .busy(busy),
    .loadDone(loadDone), .loadFault(loadFault), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .memWrReq(memWrReq), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .xlReq(xlReq), .xlSlot(xlSlot), .xlOffset(xlOffset), .xlWrite(xlWrite),
    .xlValid(xlValid), .xlLinear(xlLinear), .xlFault(xlFault)
  );

  // memory responder: one-cycle read latency
  always @(posedge clk) begin
    if (!rstN) begin
      memRdValid <= 1'b0;
    end else begin
      memRdValid <= memRdReq && !memRdValid;
      memRdData  <= mem[memRdAddr[9:2]];
      if (memRdValid) rdCount <= rdCount + 1;
      if (memWrReq) begin
        mem[memWrAddr[9:2]] <= memWrData;
        wrCount <= wrCount + 1;
      end
    end
  end

  function automatic logic [31:0] mkLo(input logic [31:0] b, input logic [19:0] l);
    return {b[15:0], l[15:0]};
  endfunction
  function automatic logic [31:0] mkHi(input logic [31:0] b, input logic [19:0] l,
                                       input logic g, input logic [7:0] acc);
    return {b[31:24], g, 1'b1, 2'b00, l[19:16], acc, b[23:16]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic setTable(input logic sel, input logic [31:0] b, input logic [15:0] l);
    @(negedge clk);
    tableWe = 1; tableSel = sel; tableBase = b; tableLimit = l;
    @(negedge clk);
    tableWe = 0;
  endtask

  task automatic doLoad(input logic [1:0] slot, input logic [15:0] sel, input logic [1:0] cp,
                        input logic [2:0] expF, input string tag, output int lat);
    @(negedge clk);
    loadReq = 1; loadSlot = slot; loadSel = sel; cpl = cp;
    @(negedge clk);
    loadReq = 0; lat = 1;
    while (!loadDone && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    check(loadDone === 1'b1 && loadFault === expF, tag, {29'd0, loadFault}, {29'd0, expF});
  endtask

  task automatic doXl(input logic [1:0] slot, input logic [31:0] off, input logic wr,
                      input logic [2:0] expF, input logic [31:0] expL, input string tag);
    @(negedge clk);
    xlReq = 1; xlSlot = slot; xlOffset = off; xlWrite = wr;
    @(negedge clk);
    xlReq = 0;
    check(xlValid === 1'b1 && xlFault === expF, {tag, " fault"}, {28'd0, xlValid, xlFault}, {28'd1, expF});
    check(xlLinear === expL, {tag, " linear"}, xlLinear, expL);
  endtask

  task automatic testReset();
    check(busy === 0 && loadDone === 0 && xlValid === 0, "R1 reset outputs",
          {29'd0, busy, loadDone, xlValid}, 32'd0);
    for (int s = 0; s < 4; s++) doXl(s[1:0], 32'h0, 1'b0, 3'd1, 32'd0, "R1 null after reset");
  endtask

  task automatic testExpandUp();
    int lat, w0;
    w0 = wrCount;
    doLoad(2'd0, 16'h000B, 2'd3, 3'd0, "R2 load global entry 1", lat);
    check(wrCount == w0 + 1 && mem[3][8] === 1'b1, "R6 accessed bit written",
          mem[3], mkHi(32'h0001_0000, 20'h00FFF, 1'b0, 8'hF3));
    doXl(2'd0, 32'h10, 1'b0, 3'd0, 32'h0001_0010, "R10 read inside");
    doXl(2'd0, 32'hFFF, 1'b0, 3'd0, 32'h0001_0FFF, "R8 offset equal limit");
    doXl(2'd0, 32'h1000, 1'b0, 3'd4, 32'd0, "R8 offset above limit");
    doXl(2'd0, 32'h20, 1'b1, 3'd0, 32'h0001_0020, "R9 write to writable data");
  endtask

  task automatic testPageGran();
    int lat, w0;
    w0 = wrCount;
    doLoad(2'd1, 16'h0010, 2'd0, 3'd0, "R5 load read-only DPL0", lat);
    check(wrCount == w0, "R6 no write when A set", wrCount, w0);
    doXl(2'd1, 32'h0, 1'b1, 3'd5, 32'd0, "R9 write to read-only");
    doXl(2'd1, 32'h0001_0FFF, 1'b0, 3'd0, 32'h2001_0FFF, "R7 page granular top");
    doXl(2'd1, 32'h0001_1000, 1'b0, 3'd4, 32'd0, "R7 page granular over");
    doXl(2'd1, 32'h0002_0000, 1'b1, 3'd5, 32'd0, "R9 rights before limit");
  endtask

  task automatic testExpandDown();
    int lat;
    doLoad(2'd2, 16'h001B, 2'd3, 3'd0, "R5 load expand-down", lat);
    doXl(2'd2, 32'h100, 1'b0, 3'd4, 32'd0, "R8 expand-down at limit");
    doXl(2'd2, 32'h101, 1'b1, 3'd0, 32'h0000_8101, "R8 expand-down above");
    doXl(2'd2, 32'hFFFF_F000, 1'b0, 3'd0, 32'h0000_7000, "R10 wraps modulo 2^32");
  endtask

  task automatic testCode();
    int lat;
    doLoad(2'd3, 16'h0023, 2'd3, 3'd0, "R5 load execute-only code", lat);
    doXl(2'd3, 32'h0, 1'b0, 3'd5, 32'd0, "R9 read of execute-only");
    doXl(2'd3, 32'h0, 1'b1, 3'd5, 32'd0, "R9 write to code");
  endtask

  task automatic testLoadFaults();
    int lat;
    doLoad(2'd0, 16'h002B, 2'd3, 3'd3, "R5 not present", lat);
    doXl(2'd0, 32'h10, 1'b0, 3'd0, 32'h0001_0010, "R5 slot kept after fault");
    doLoad(2'd0, 16'h0030, 2'd0, 3'd5, "R5 system descriptor", lat);
    doLoad(2'd0, 16'h0038, 2'd3, 3'd6, "R5 CPL above DPL", lat);
    doLoad(2'd0, 16'h003B, 2'd0, 3'd6, "R5 RPL above DPL", lat);
    doLoad(2'd3, 16'h0038, 2'd0, 3'd0, "R5 equal privilege", lat);
    doXl(2'd3, 32'h5, 1'b1, 3'd0, 32'h0060_0005, "R5 privileged slot usable");
  endtask

  task automatic testTables();
    int lat, r0;
    r0 = rdCount;
    doLoad(2'd1, 16'h0040, 2'd0, 3'd2, "R3 global index past limit", lat);
    check(lat == 2, "R3 fault latency", lat, 2);
    check(rdCount == r0, "R3 no memory read", rdCount, r0);
    doLoad(2'd1, 16'h0027, 2'd3, 3'd2, "R3 local index past limit", lat);
    doLoad(2'd1, 16'h0007, 2'd3, 3'd0, "R4 local index 0 is ordinary", lat);
    doXl(2'd1, 32'hFF, 1'b0, 3'd0, 32'h5000_00FF, "R2 local table translate");
    doXl(2'd1, 32'h100, 1'b0, 3'd4, 32'd0, "R8 local limit");
    doLoad(2'd2, 16'h001F, 2'd3, 3'd0, "R3 last entry inside limit", lat);
    doXl(2'd2, 32'h10, 1'b0, 3'd0, 32'h5000_0010, "R2 local entry 3");
  endtask

  task automatic testNull();
    int lat, r0;
    r0 = rdCount;
    doLoad(2'd2, 16'h0003, 2'd3, 3'd0, "R4 null load accepted", lat);
    check(lat == 2 && rdCount == r0, "R4 null load no read", lat, 2);
    doXl(2'd2, 32'h0, 1'b0, 3'd1, 32'd0, "R4 null slot use");
  endtask

  task automatic testBusy();
    int lat;
    @(negedge clk);
    loadReq = 1; loadSlot = 2'd0; loadSel = 16'h000B; cpl = 2'd3;
    @(negedge clk);
    loadReq = 0;
    check(busy === 1'b1, "R11 busy after load request", {31'd0, busy}, 32'd1);
    xlReq = 1; xlSlot = 2'd0; xlOffset = 32'h0;
    loadReq = 1; loadSel = 16'h0003;
    @(negedge clk);
    xlReq = 0; loadReq = 0;
    check(xlValid === 1'b0, "R11 translation ignored while busy", {31'd0, xlValid}, 32'd0);
    lat = 0;
    while (!loadDone && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    check(loadDone === 1'b1 && loadFault === 3'd0, "R11 load completes", {29'd0, loadFault}, 32'd0);
    @(negedge clk);
    check(loadDone === 1'b0 && busy === 1'b0, "R11 single done pulse", {30'd0, loadDone, busy}, 32'd0);
    doXl(2'd0, 32'h4, 1'b0, 3'd0, 32'h0001_0004, "R11 second load ignored");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    mem[2]  = mkLo(32'h0001_0000, 20'h00FFF); mem[3]  = mkHi(32'h0001_0000, 20'h00FFF, 1'b0, 8'hF2);
    mem[4]  = mkLo(32'h2000_0000, 20'h00010); mem[5]  = mkHi(32'h2000_0000, 20'h00010, 1'b1, 8'h91);
    mem[6]  = mkLo(32'h0000_8000, 20'h00100); mem[7]  = mkHi(32'h0000_8000, 20'h00100, 1'b0, 8'hF7);
    mem[8]  = mkLo(32'h0000_4000, 20'hFFFFF); mem[9]  = mkHi(32'h0000_4000, 20'hFFFFF, 1'b1, 8'hF9);
    mem[10] = mkLo(32'h0000_9000, 20'h000FF); mem[11] = mkHi(32'h0000_9000, 20'h000FF, 1'b0, 8'h72);
    mem[12] = mkLo(32'h0000_A000, 20'h000FF); mem[13] = mkHi(32'h0000_A000, 20'h000FF, 1'b0, 8'h82);
    mem[14] = mkLo(32'h0060_0000, 20'h000FF); mem[15] = mkHi(32'h0060_0000, 20'h000FF, 1'b0, 8'h93);
    mem[128] = mkLo(32'h5000_0000, 20'h000FF); mem[129] = mkHi(32'h5000_0000, 20'h000FF, 1'b0, 8'hF3);
    mem[134] = mkLo(32'h5000_0000, 20'h000FF); mem[135] = mkHi(32'h5000_0000, 20'h000FF, 1'b0, 8'hF3);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    setTable(1'b0, 32'h0000_0000, 16'h003F);
    setTable(1'b1, 32'h0000_0200, 16'h001F);
    testExpandUp();
    testPageGran();
    testExpandDown();
    testCode();
    testLoadFaults();
    testTables();
    testNull();
    testBusy();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule